// File: doc/BRIEF.md
# Section-Based Variable-Length Code Decoder

This block turns the head of a variable-length coded bitstream back into a symbol. Each cycle it may accept a window of `W` bits, where `W` is the width of the longest codeword, taken from the current head of the stream. The window is captured into a register. A bank of comparators then finds the section the window belongs to. A section is a run of consecutive codewords that share a length and a leading class. The selected section's representative supplies three values: a zero-padded codeword, a length and a sorted address.

The symbol's sorted address is recovered by arithmetic rather than by a tree walk or a full table search. The representative's padded codeword is subtracted from the window. The difference is shifted right by `W` minus the length, and the representative's address is added. A small inverse map turns that sorted address into the symbol identifier.

Alongside the symbol, the block reports the codeword length. An upstream shifter uses this length to advance the stream. Managing the stream buffer lies outside this block.

Top module: `vlcd_decoder`

## Requirements
- R1: Every cycle with `in_valid` high produces exactly one cycle of `out_valid`, LAT cycles later, where LAT is 2 + `PIPE` (3 by default). No other cycle raises `out_valid`. While `out_valid` is low, `out_sym` and `out_len` keep their previous values.
- R2: While `rst_n` is low, and after it, until the first result, `out_valid`, `out_sym` and `out_len` are all zero.
- R3: The section chosen is the highest-indexed one whose restored padded representative codeword is less than or equal to the window, read as an unsigned number. Windows on either side of a section boundary decode into different sections.
- R4: Representative codewords are stored without their `OMIT` low bits, which are all zero. Wiring restores these bits. A window equal to a representative's padded codeword decodes to that representative's own symbol.
- R5: The sorted address equals ((window − representative codeword) >> (`W` − representative length)) + representative address.
- R6: `out_sym` is the symbol held at the computed sorted address. The default code is left-aligned, most significant bit first, with `W`=4. Each symbol maps to its codeword as follows:
  - 5 → `00`
  - 2 → `010`
  - 7 → `011`
  - 0 → `100`
  - 8 → `1010`
  - 3 → `1011`
  - 1 → `110`
  - 6 → `1110`
  - 4 → `1111`
- R7: `out_len` equals the length of the decoded codeword, which is the length of its section's representative.
- R8: The window bits below the codeword length have no effect on `out_sym` or `out_len`.
- R9: Windows presented on consecutive cycles are all decoded, and their results appear in the order the windows arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window present this cycle |
| in_window | input | W | Head of the bitstream, first bit in the MSB |
| out_valid | output | 1 | Decoded result present |
| out_sym | output | SYMW | Decoded symbol identifier |
| out_len | output | LW | Codeword length in bits, used to advance the stream |

## Verification
Two things can happen in the same cycle. A fresh window can be captured into the head register while the previous window's section selection and address arithmetic are still under way, and while an earlier result is leaving the output register. The bench provokes this by sending every possible window on consecutive cycles. It also sends round-trip codewords back to back across section boundaries, such as `1001` followed by `1010`. A scoreboard pops one expected symbol, length and arrival cycle per result. A result that is late, early, reordered or that carries the fields of its neighbour is counted as a mismatch.

// File: rtl/vlcd_pkg.sv
package vlcd_pkg;

   // Default code geometry
   localparam int unsigned DEF_W    = 4;
   localparam int unsigned DEF_NSYM = 9;
   localparam int unsigned DEF_NSEC = 6;
   localparam int unsigned DEF_OMIT = 1;

   localparam int unsigned DEF_LW   = $clog2(DEF_W + 1);
   localparam int unsigned DEF_AW   = $clog2(DEF_NSYM);
   localparam int unsigned DEF_SYMW = $clog2(DEF_NSYM);
   localparam int unsigned DEF_CWS  = DEF_W - DEF_OMIT;

   // Section representatives, section 0 in the least significant slot.
   // Stored codewords drop the DEF_OMIT trailing zero bits.
   localparam logic [DEF_NSEC*DEF_CWS-1:0] DEF_REP_CW =
      {3'b111, 3'b110, 3'b101, 3'b100, 3'b010, 3'b000};
   localparam logic [DEF_NSEC*DEF_LW-1:0] DEF_REP_LEN =
      {3'd4, 3'd3, 3'd4, 3'd3, 3'd3, 3'd2};
   localparam logic [DEF_NSEC*DEF_AW-1:0] DEF_REP_ADDR =
      {4'd7, 4'd6, 4'd4, 4'd3, 4'd1, 4'd0};

   // Sorted address to symbol, address 0 in the least significant slot
   localparam logic [DEF_NSYM*DEF_SYMW-1:0] DEF_INV_MAP =
      {4'd4, 4'd6, 4'd1, 4'd3, 4'd8, 4'd0, 4'd7, 4'd2, 4'd5};

   typedef enum logic {
      STAGE_FLOW = 1'b0,
      STAGE_REG  = 1'b1
   } vlcd_stage_e;

endpackage

// File: rtl/vlcd_sec_select.sv
module vlcd_sec_select #(
   parameter int unsigned W    = 4,
   parameter int unsigned NSEC = 6,
   parameter int unsigned OMIT = 1,
   parameter int unsigned LW   = 3,
   parameter int unsigned AW   = 4,
   parameter logic [NSEC*(W-OMIT)-1:0] REP_CW   = '0,
   parameter logic [NSEC*LW-1:0]       REP_LEN  = '0,
   parameter logic [NSEC*AW-1:0]       REP_ADDR = '0
) (
   input  logic [W-1:0]  win,
   output logic [W-1:0]  rep_cw,
   output logic [LW-1:0] rep_len,
   output logic [AW-1:0] rep_addr
);

   localparam int unsigned CWS = W - OMIT;

   logic [W-1:0]    restored [NSEC];
   logic [NSEC-1:0] ge;

   // Restore the dropped low zeros and compare the window against each
   // representative.
   for (genvar s = 0; s < NSEC; s++) begin : g_sec
      if (OMIT > 0) begin : g_pad
         assign restored[s] = {REP_CW[s*CWS +: CWS], {OMIT{1'b0}}};
      end else begin : g_full
         assign restored[s] = REP_CW[s*CWS +: CWS];
      end
      assign ge[s] = (win >= restored[s]);
   end

   // Sorted representatives form a thermometer; the last one passed wins.
   always_comb begin
      rep_cw   = restored[0];
      rep_len  = REP_LEN[0 +: LW];
      rep_addr = REP_ADDR[0 +: AW];
      for (int s = 1; s < NSEC; s++) begin
         if (ge[s]) begin
            rep_cw   = restored[s];
            rep_len  = REP_LEN[s*LW +: LW];
            rep_addr = REP_ADDR[s*AW +: AW];
         end
      end
   end

endmodule

// File: rtl/vlcd_addr_calc.sv
module vlcd_addr_calc #(
   parameter int unsigned W  = 4,
   parameter int unsigned LW = 3,
   parameter int unsigned AW = 4
) (
   input  logic [W-1:0]  win,
   input  logic [W-1:0]  rep_cw,
   input  logic [LW-1:0] rep_len,
   input  logic [AW-1:0] rep_addr,
   output logic [AW-1:0] addr
);

   logic [W-1:0]  offset;
   logic [LW-1:0] shamt;
   logic [W-1:0]  diff;

   always_comb begin
      offset = win - rep_cw;
      shamt  = LW'(W) - rep_len;
      diff   = offset >> shamt;
   end

   // The width of the addition follows the relation between W and AW.
   if (AW >= W) begin : g_wide
      assign addr = AW'(diff) + rep_addr;
   end else begin : g_narrow
      logic [W-1:0] sum_w;
      assign sum_w = diff + W'(rep_addr);
      assign addr  = sum_w[AW-1:0];
   end

endmodule

// File: rtl/vlcd_sym_map.sv
module vlcd_sym_map #(
   parameter int unsigned NSYM = 9,
   parameter int unsigned AW   = 4,
   parameter int unsigned SYMW = 4,
   parameter logic [NSYM*SYMW-1:0] INV_MAP = '0
) (
   input  logic [AW-1:0]   addr,
   output logic [SYMW-1:0] sym
);

   logic [NSYM-1:0] hit;

   for (genvar a = 0; a < NSYM; a++) begin : g_hit
      assign hit[a] = (addr == AW'(a));
   end

   always_comb begin
      sym = '0;
      for (int a = 0; a < NSYM; a++) begin
         if (hit[a]) sym = INV_MAP[a*SYMW +: SYMW];
      end
   end

endmodule

// File: rtl/vlcd_decoder.sv
module vlcd_decoder #(
   parameter int unsigned W    = vlcd_pkg::DEF_W,
   parameter int unsigned NSYM = vlcd_pkg::DEF_NSYM,
   parameter int unsigned NSEC = vlcd_pkg::DEF_NSEC,
   parameter int unsigned OMIT = vlcd_pkg::DEF_OMIT,
   parameter int unsigned LW   = $clog2(W + 1),
   parameter int unsigned AW   = $clog2(NSYM),
   parameter int unsigned SYMW = $clog2(NSYM),
   parameter bit          PIPE = vlcd_pkg::STAGE_REG,
   parameter logic [NSEC*(W-OMIT)-1:0] REP_CW   = vlcd_pkg::DEF_REP_CW,
   parameter logic [NSEC*LW-1:0]       REP_LEN  = vlcd_pkg::DEF_REP_LEN,
   parameter logic [NSEC*AW-1:0]       REP_ADDR = vlcd_pkg::DEF_REP_ADDR,
   parameter logic [NSYM*SYMW-1:0]     INV_MAP  = vlcd_pkg::DEF_INV_MAP
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [W-1:0]    in_window,
   output logic            out_valid,
   output logic [SYMW-1:0] out_sym,
   output logic [LW-1:0]   out_len
);

   // Elaboration-time parameter checks
   if (W < 2) begin : g_bad_w
      $error("vlcd_decoder: W must be at least 2");
   end
   if (OMIT >= W) begin : g_bad_omit
      $error("vlcd_decoder: OMIT must be below W");
   end
   if (NSEC < 1 || NSEC > NSYM) begin : g_bad_nsec
      $error("vlcd_decoder: NSEC must lie in 1..NSYM");
   end
   if (NSYM < 2) begin : g_bad_nsym
      $error("vlcd_decoder: NSYM must be at least 2");
   end
   if ((1 << AW) < NSYM) begin : g_bad_aw
      $error("vlcd_decoder: AW too narrow for NSYM");
   end
   if ((1 << LW) <= W) begin : g_bad_lw
      $error("vlcd_decoder: LW too narrow to hold W");
   end

   // Head register R
   logic         r_valid;
   logic [W-1:0] r_win;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r_valid <= 1'b0;
         r_win   <= '0;
      end else begin
         r_valid <= in_valid;
         if (in_valid) r_win <= in_window;
      end
   end

   // Section selection
   logic [W-1:0]  s_cw;
   logic [LW-1:0] s_len;
   logic [AW-1:0] s_addr;

   vlcd_sec_select #(
      .W(W), .NSEC(NSEC), .OMIT(OMIT), .LW(LW), .AW(AW),
      .REP_CW(REP_CW), .REP_LEN(REP_LEN), .REP_ADDR(REP_ADDR)
   ) i_sec_select (
      .win      (r_win),
      .rep_cw   (s_cw),
      .rep_len  (s_len),
      .rep_addr (s_addr)
   );

   // Optional stage between selection and arithmetic
   logic          m_valid;
   logic [W-1:0]  m_win;
   logic [W-1:0]  m_cw;
   logic [LW-1:0] m_len;
   logic [AW-1:0] m_addr;

   if (PIPE) begin : g_mid_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            m_valid <= 1'b0;
            m_win   <= '0;
            m_cw    <= '0;
            m_len   <= '0;
            m_addr  <= '0;
         end else begin
            m_valid <= r_valid;
            if (r_valid) begin
               m_win  <= r_win;
               m_cw   <= s_cw;
               m_len  <= s_len;
               m_addr <= s_addr;
            end
         end
      end
   end else begin : g_mid_flow
      assign m_valid = r_valid;
      assign m_win   = r_win;
      assign m_cw    = s_cw;
      assign m_len   = s_len;
      assign m_addr  = s_addr;
   end

   // Address recovery and inverse map
   logic [AW-1:0]   c_addr;
   logic [SYMW-1:0] c_sym;

   vlcd_addr_calc #(.W(W), .LW(LW), .AW(AW)) i_addr_calc (
      .win      (m_win),
      .rep_cw   (m_cw),
      .rep_len  (m_len),
      .rep_addr (m_addr),
      .addr     (c_addr)
   );

   vlcd_sym_map #(.NSYM(NSYM), .AW(AW), .SYMW(SYMW), .INV_MAP(INV_MAP)) i_sym_map (
      .addr (c_addr),
      .sym  (c_sym)
   );

   // Output register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sym   <= '0;
         out_len   <= '0;
      end else begin
         out_valid <= m_valid;
         if (m_valid) begin
            out_sym <= c_sym;
            out_len <= m_len;
         end
      end
   end

endmodule

// File: rtl/vlcd_decoder_chk.sv
module vlcd_decoder_chk #(
   parameter int unsigned W    = 4,
   parameter int unsigned NSYM = 9,
   parameter int unsigned LW   = 3,
   parameter int unsigned SYMW = 4,
   parameter bit          PIPE = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [W-1:0]    in_window,
   input logic            out_valid,
   input logic [SYMW-1:0] out_sym,
   input logic [LW-1:0]   out_len
);

   localparam int unsigned LAT = 2 + int'(PIPE);

   // R1: one result per accepted window, exactly LAT cycles later
   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid, LAT));

   // R1: outputs hold while no result is presented
   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(out_sym) && $stable(out_len)));

   // R7: a reported length is a real codeword length
   p_len_bounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_len != '0 && out_len <= LW'(W)));

   // R6: the symbol is one of the coded symbols
   p_sym_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (32'(out_sym) < NSYM));

   // R3: repeating a window back to back repeats the decode
   p_same_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid)
       && $past(in_window, LAT) == $past(in_window, LAT + 1))
      |-> ($stable(out_sym) && $stable(out_len)));

endmodule

bind vlcd_decoder vlcd_decoder_chk #(
   .W(W), .NSYM(NSYM), .LW(LW), .SYMW(SYMW), .PIPE(PIPE)
) i_vlcd_decoder_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_window (in_window),
   .out_valid (out_valid),
   .out_sym   (out_sym),
   .out_len   (out_len)
);

// File: tb/test_vlcd_decoder.sv
module test_vlcd_decoder;

   localparam int W    = 4;
   localparam int LW   = 3;
   localparam int SYMW = 4;
   localparam int NSYM = 9;
   localparam bit PIPE = 1'b1;
   localparam int LAT  = 2 + int'(PIPE);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [W-1:0]    in_window = '0;
   logic            out_valid;
   logic [SYMW-1:0] out_sym;
   logic [LW-1:0]   out_len;

   always #2.5 clk = ~clk;   // 200 MHz

   vlcd_decoder #(.PIPE(PIPE)) i_vlcd_decoder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_window(in_window),
      .out_valid(out_valid), .out_sym(out_sym), .out_len(out_len)
   );

   // Code of R6, left aligned, indexed by symbol
   logic [W-1:0] code_pad [NSYM] = '{4'b1000, 4'b1100, 4'b0100, 4'b1011,
                                     4'b1111, 4'b0000, 4'b1110, 4'b0110, 4'b1010};
   int           code_len [NSYM] = '{3, 3, 3, 4, 4, 2, 4, 3, 4};

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   int    q_sym [$];
   int    q_len [$];
   int    q_cyc [$];
   string q_tag [$];

   always @(posedge clk) cyc <= cyc + 1;

   // Prefix match over the whole code, independent of section tables
   function automatic void ref_decode(input logic [W-1:0] win, output int sym, output int len);
      sym = -1; len = 0;
      for (int s = 0; s < NSYM; s++) begin
         if ((win >> (W - code_len[s])) == (code_pad[s] >> (W - code_len[s]))) begin
            sym = s; len = code_len[s];
         end
      end
   endfunction

   task automatic send(input logic [W-1:0] win, input string tag);
      int es, el;
      @(negedge clk);
      ref_decode(win, es, el);
      in_valid  = 1'b1;
      in_window = win;
      q_sym.push_back(es);
      q_len.push_back(el);
      q_cyc.push_back(cyc + LAT);
      q_tag.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid  = 1'b0;
         in_window = 4'(i * 5 + 3);
      end
   endtask

   // Monitor: scoreboard compare
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            checks++;
            if (q_sym.size() == 0) begin
               fails++;
               $display("FAIL R1: unexpected result sym=%0d len=%0d, expected none", out_sym, out_len);
            end else begin
               int es, el, ec;
               string tg;
               es = q_sym.pop_front(); el = q_len.pop_front();
               ec = q_cyc.pop_front(); tg = q_tag.pop_front();
               if (ec != cyc) begin
                  fails++;
                  $display("FAIL R1/%s: result at cycle %0d, expected cycle %0d", tg, cyc, ec);
               end else if (int'(out_sym) != es || int'(out_len) != el) begin
                  fails++;
                  $display("FAIL %s: sym=%0d len=%0d, expected sym=%0d len=%0d",
                           tg, out_sym, out_len, es, el);
               end
            end
         end else if (q_cyc.size() != 0 && q_cyc[0] <= cyc) begin
            checks++;
            fails++;
            $display("FAIL R1/%s: no result at cycle %0d, expected one", q_tag[0], cyc);
            void'(q_sym.pop_front()); void'(q_len.pop_front());
            void'(q_cyc.pop_front()); void'(q_tag.pop_front());
         end
      end
   end

   // Watchdog
   always @(posedge clk) begin
      if (cyc == 50000) begin
         fails++;
         $display("FAIL R1: watchdog expired, got hang, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R2: reset state
      checks++;
      if (out_valid !== 1'b0 || out_sym !== '0 || out_len !== '0) begin
         fails++;
         $display("FAIL R2: valid=%b sym=%0d len=%0d, expected 0 0 0", out_valid, out_sym, out_len);
      end
      @(negedge clk);
      rst_n = 1'b1;
      idle(3);
      checks++;
      if (out_valid !== 1'b0 || out_sym !== '0 || out_len !== '0) begin
         fails++;
         $display("FAIL R2: after release valid=%b sym=%0d len=%0d, expected 0 0 0",
                  out_valid, out_sym, out_len);
      end

      // R5 / R9: every window, back to back
      for (int w = 0; w < (1 << W); w++) send(4'(w), "R5");
      idle(4);

      // R4: windows equal to each representative
      send(4'b0000, "R4"); send(4'b0100, "R4"); send(4'b1000, "R4");
      send(4'b1010, "R4"); send(4'b1100, "R4"); send(4'b1110, "R4");
      idle(2);

      // R3: section boundaries, back to back and repeated
      send(4'b1001, "R3"); send(4'b1010, "R3"); send(4'b1011, "R3");
      send(4'b1101, "R3"); send(4'b1110, "R3"); send(4'b0011, "R3");
      send(4'b0100, "R3"); send(4'b0100, "R3");
      idle(3);

      // R6 / R7 / R8: round trip with random trailing fill, with gaps
      for (int rep = 0; rep < 6; rep++) begin
         for (int s = 0; s < NSYM; s++) begin
            logic [W-1:0] fill;
            fill = 4'($urandom) & 4'((1 << (W - code_len[s])) - 1);
            send(code_pad[s] | fill, (rep % 2 == 0) ? "R8" : "R6");
            if ((s + rep) % 3 == 0) idle(1 + (s % 2));
         end
      end

      // R9 / R7: long burst then drain
      for (int k = 0; k < 40; k++) send(4'($urandom), (k % 2 == 0) ? "R9" : "R7");
      idle(LAT + 4);

      checks++;
      if (q_sym.size() != 0) begin
         fails++;
         $display("FAIL R9: %0d results outstanding, expected 0", q_sym.size());
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule